// File: doc/BRIEF.md
# Capture/Compare 16-bit Timer

This block is a 16-bit up-counter fed by a power-of-two prescaler. It has two operating modes, selected in a control byte. In compare mode the counter runs freely. Each time it passes a programmed compare value, the block pulses an interrupt and can invert an output pin. The counter itself is never cleared by a match; it rolls over only after its all-ones value. In capture mode the counter counts up to a reload value and then restarts at one. An edge of the selected polarity on a synchronised input pin copies the running count into a capture register.

Software reaches the block through a byte-wide register port. Reading the high byte of the count or of the capture value freezes the matching low byte, so two byte reads return a coherent 16-bit value. A capture register cleared to zero before a run lets software tell a capture interrupt from a reload interrupt. A two-bit source field selects which of the two events may raise the interrupt.

Top module: `cc_timer16`

## Requirements
- R1: After reset every readable register returns 0x00, tout_o is low and irq_o is low. Address map: 0 control, 1 pin control, 2/3 count high/low, 4/5 compare-reload high/low, 6/7 capture high/low, 8 status.
- R2: Control byte: bit 7 enable, bit 6 mode (0 compare, 1 capture), bit 5 idle output level, bits 4:2 prescale exponent N, bits 1:0 interrupt source. While enabled, the count advances once every 2^N clocks. The first advance takes effect 2^N clock edges after the edge that wrote the enable.
- R3: The count bytes can be written only while the timer is disabled. A count write while enabled leaves the count unchanged.
- R4: In compare mode, a prescaled tick while the count equals the compare value moves the count to compare+1. On that same edge it raises a one-cycle irq_o pulse and sets status bit 1.
- R5: Pin control bit 1 enables the output. When it is set, each compare match inverts tout_o on the edge that advances the count. When it is clear, tout_o holds its level.
- R6: In compare mode the count wraps from 0xFFFF to 0x0000 and keeps counting.
- R7: While disabled, tout_o follows the idle level bit, one clock after that bit is written.
- R8: In capture mode, a tick while the count equals the reload value sets the count to 0x0001 and makes a reload event. The reload event sets status bit 1 and leaves the capture register untouched.
- R9: Pin control bit 0 selects the capture edge (1 rising, 0 falling). In capture mode, an edge of that polarity on tin_i, after a two-flop synchroniser, copies the count into the capture register and sets status bit 0. An edge of the other polarity does nothing.
- R10: In capture mode the source field decides which events raise irq_o: 00 or 11 both, 01 capture only, 10 reload only. A masked event still sets its status bit.
- R11: Reading the count or capture high byte latches the low byte. The next low-byte read returns that latched value.
- R12: Writing 1 to a status bit clears it. An event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Register read strobe (triggers low-byte latching) |
| rd_data_o | output | 8 | Read data for addr_i, combinational |
| tin_i | input | 1 | Capture input pin, asynchronous |
| tout_o | output | 1 | Timer output pin |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The embedded properties check, on every cycle, the cycle-local rules of the counter:
- the restart to one after a reload;
- the wrap after all ones;
- the compare+1 step on a match;
- the inversion of the output on an enabled match;
- the idle output level;
- a frozen count between ticks;
- the copy of the count on capture;
- the sticky status set;
- interrupt masking.

Only the directed scenarios can show end-to-end effects. These are the exact tick spacing for a given prescale exponent, the ignored count write while running, the coherent two-byte read across a byte carry, the polarity filter on the input pin, and the zero-capture signature that marks a reload interrupt.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CNT_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int PRE_SEL_W = 3;
  localparam int STAT_W    = 2;

  localparam logic [ADDR_W-1:0] A_CTRL0 = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL1 = 4'd1;
  localparam logic [ADDR_W-1:0] A_CNT_H = 4'd2;
  localparam logic [ADDR_W-1:0] A_CNT_L = 4'd3;
  localparam logic [ADDR_W-1:0] A_RLD_H = 4'd4;
  localparam logic [ADDR_W-1:0] A_RLD_L = 4'd5;
  localparam logic [ADDR_W-1:0] A_CAP_H = 4'd6;
  localparam logic [ADDR_W-1:0] A_CAP_L = 4'd7;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd8;

  typedef enum logic {MODE_CMP = 1'b0, MODE_CAP = 1'b1} mode_e;
  typedef enum logic [1:0] {
    SRC_BOTH = 2'd0, SRC_CAP = 2'd1, SRC_RLD = 2'd2, SRC_ALL = 2'd3
  } irq_src_e;

  typedef struct packed {
    logic                 en;
    mode_e                mode;
    logic                 init_lvl;
    logic [PRE_SEL_W-1:0] pres;
    irq_src_e             src;
  } ctrl_t;
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(sel_i));
  end

  assign tick_o = en_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (!en_i) pre_q <= '0;
    else            pre_q <= pre_q + DIV_W'(1);
  end

  assert_pre_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pre_q == '0));
endmodule

// File: rtl/cct_edge.sv
module cct_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign s      = sync_q[STAGES-1];
  assign edge_o = rise_i ? (s & ~last_q) : (~s & last_q);

  // a single pin transition yields exactly one event
  assert_single_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (!edge_o || (rise_i != $past(rise_i))));
endmodule

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  mode_e             mode_i,
  input  logic              init_i,
  input  logic              out_en_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  rld_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [BYTE_W-1:0] ld_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              hit_o,
  output logic              tout_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             out_q;

  assign hit_o  = tick_i && (cnt_q == rld_i);
  assign cnt_o  = cnt_q;
  assign tout_o = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i) begin
      if (ld_hi_i) cnt_q[CNT_W-1:BYTE_W] <= ld_data_i;
      if (ld_lo_i) cnt_q[BYTE_W-1:0]     <= ld_data_i;
    end else if (tick_i) begin
      if (mode_i == MODE_CAP && hit_o) cnt_q <= CNT_W'(1);
      else                             cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        out_q <= 1'b0;
    else if (!en_i)                                     out_q <= init_i;
    else if (mode_i == MODE_CMP && hit_o && out_en_i)   out_q <= ~out_q;
  end

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_q));
  assert_cmp_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hit_o && mode_i == MODE_CMP) |=> (cnt_q == $past(rld_i) + CNT_W'(1)));
  assert_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hit_o && mode_i == MODE_CMP && out_en_i) |=> (tout_o != $past(tout_o)));
  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && mode_i == MODE_CMP && cnt_q == '1) |=> (cnt_q == '0));
  assert_idle_lvl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (tout_o == $past(init_i)));
  assert_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hit_o && mode_i == MODE_CAP) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/cc_timer16.sv
module cc_timer16
  import cct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              tin_i,
  output logic              tout_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic              cap_rise_q, out_en_q;
  logic [CNT_W-1:0]  rld_q, cap_q, cnt;
  logic [BYTE_W-1:0] cnt_lo_sh_q, cap_lo_sh_q;
  logic [STAT_W-1:0] stat_q, stat_clr;
  logic              irq_q, irq_d;
  logic              tick, hit, pin_edge, cap_evt;
  logic              wr_ctrl0, wr_ctrl1, wr_stat;

  assign wr_ctrl0 = wr_en_i && addr_i == A_CTRL0;
  assign wr_ctrl1 = wr_en_i && addr_i == A_CTRL1;
  assign wr_stat  = wr_en_i && addr_i == A_STAT;

  cct_prescaler #(.SEL_W(PRE_SEL_W)) u_pre (
    .clk_i, .rst_ni, .en_i(ctrl_q.en), .sel_i(ctrl_q.pres), .tick_o(tick)
  );

  cct_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .pin_i(tin_i), .rise_i(cap_rise_q), .edge_o(pin_edge)
  );

  cct_counter u_cnt (
    .clk_i, .rst_ni,
    .en_i      (ctrl_q.en),
    .mode_i    (ctrl_q.mode),
    .init_i    (ctrl_q.init_lvl),
    .out_en_i  (out_en_q),
    .tick_i    (tick),
    .rld_i     (rld_q),
    .ld_hi_i   (wr_en_i && addr_i == A_CNT_H && !ctrl_q.en),
    .ld_lo_i   (wr_en_i && addr_i == A_CNT_L && !ctrl_q.en),
    .ld_data_i (wr_data_i),
    .cnt_o     (cnt),
    .hit_o     (hit),
    .tout_o    (tout_o)
  );

  assign cap_evt  = ctrl_q.en && ctrl_q.mode == MODE_CAP && pin_edge;
  assign stat_clr = wr_stat ? wr_data_i[STAT_W-1:0] : '0;

  always_comb begin
    if (ctrl_q.mode == MODE_CMP) irq_d = hit;
    else irq_d = (cap_evt && ctrl_q.src != SRC_RLD) || (hit && ctrl_q.src != SRC_CAP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      cap_rise_q  <= 1'b0;
      out_en_q    <= 1'b0;
      rld_q       <= '0;
      cap_q       <= '0;
      stat_q      <= '0;
      cnt_lo_sh_q <= '0;
      cap_lo_sh_q <= '0;
      irq_q       <= 1'b0;
    end else begin
      if (wr_ctrl0) ctrl_q <= ctrl_t'(wr_data_i);
      if (wr_ctrl1) {out_en_q, cap_rise_q} <= wr_data_i[1:0];
      if (wr_en_i && addr_i == A_RLD_H) rld_q[CNT_W-1:BYTE_W] <= wr_data_i;
      if (wr_en_i && addr_i == A_RLD_L) rld_q[BYTE_W-1:0]     <= wr_data_i;
      if (cap_evt) begin
        cap_q <= cnt;
      end else begin
        if (wr_en_i && addr_i == A_CAP_H) cap_q[CNT_W-1:BYTE_W] <= wr_data_i;
        if (wr_en_i && addr_i == A_CAP_L) cap_q[BYTE_W-1:0]     <= wr_data_i;
      end
      stat_q <= (stat_q & ~stat_clr) | {hit, cap_evt};
      if (rd_en_i && addr_i == A_CNT_H) cnt_lo_sh_q <= cnt[BYTE_W-1:0];
      if (rd_en_i && addr_i == A_CAP_H) cap_lo_sh_q <= cap_q[BYTE_W-1:0];
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    case (addr_i)
      A_CTRL0: rd_data_o = ctrl_q;
      A_CTRL1: rd_data_o = {6'b0, out_en_q, cap_rise_q};
      A_CNT_H: rd_data_o = cnt[CNT_W-1:BYTE_W];
      A_CNT_L: rd_data_o = cnt_lo_sh_q;
      A_RLD_H: rd_data_o = rld_q[CNT_W-1:BYTE_W];
      A_RLD_L: rd_data_o = rld_q[BYTE_W-1:0];
      A_CAP_H: rd_data_o = cap_q[CNT_W-1:BYTE_W];
      A_CAP_L: rd_data_o = cap_lo_sh_q;
      A_STAT:  rd_data_o = {{(BYTE_W-STAT_W){1'b0}}, stat_q};
      default: rd_data_o = '0;
    endcase
  end

  assert_cap_copy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> (cap_q == $past(cnt)));
  assert_src_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt && !hit && ctrl_q.mode == MODE_CAP && ctrl_q.src == SRC_RLD) |=> !irq_q);
  assert_flag_set_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && cap_evt) |=> (stat_q == 2'b11));
  assert_flag_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[1] && !wr_stat) |=> stat_q[1]);
endmodule

// File: tb/cc_timer16_test.sv
`timescale 1ns/1ps
module cc_timer16_test;
  import cct_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, tin = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tout, irq;
  int         vectors = 0, miscmp = 0, irq_seen = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  cc_timer16 uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_en_i(rd_en), .rd_data_o(rdata),
    .tin_i(tin), .tout_o(tout), .irq_o(irq)
  );

  always @(negedge clk) if (irq) irq_seen++;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] a_hi, output logic [15:0] v);
    logic [7:0] h, l;
    rd8(a_hi, h);
    rd8(a_hi + 4'd1, l);
    v = {h, l};
  endtask

  task automatic wr16(input logic [3:0] a_hi, input logic [15:0] v);
    wr(a_hi, v[15:8]);
    wr(a_hi + 4'd1, v[7:0]);
  endtask

  task automatic t_reset;
    logic [7:0]  b;
    logic [15:0] v;
    chk("R1 tout", 16'(tout), 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
    rd8(A_CTRL0, b);  chk("R1 ctrl0", 16'(b), 16'h0);
    rd8(A_CTRL1, b);  chk("R1 ctrl1", 16'(b), 16'h0);
    rd16(A_CNT_H, v); chk("R1 count", v, 16'h0);
    rd16(A_RLD_H, v); chk("R1 reload", v, 16'h0);
    rd16(A_CAP_H, v); chk("R1 capture", v, 16'h0);
    rd8(A_STAT, b);   chk("R1 status", 16'(b), 16'h0);
  endtask

  // N=2: one advance every 4 clocks; count write while running ignored
  task automatic t_prescale;
    logic [15:0] v;
    wr16(A_CNT_H, 16'h0000);
    wr16(A_RLD_H, 16'h8000);
    wr(A_CTRL0, 8'h88);
    repeat (3) @(negedge clk);
    rd16(A_CNT_H, v); chk("R2 before first tick", v, 16'h0000);
    repeat (3) @(negedge clk);
    rd16(A_CNT_H, v); chk("R2 after 8 clocks", v, 16'h0002);
    wr(A_CNT_L, 8'hAA);
    rd16(A_CNT_H, v); chk("R3 write while running", v, 16'h0002);
    wr(A_CTRL0, 8'h00);
    rd16(A_CNT_H, v); chk("R2 frozen on disable", v, 16'h0003);
    wr16(A_CNT_H, 16'hBEEF);
    rd16(A_CNT_H, v); chk("R3 write while idle", v, 16'hBEEF);
  endtask

  task automatic t_compare;
    logic [15:0] v;
    logic [7:0]  b;
    int base;
    wr(A_CTRL1, 8'h02);
    wr16(A_CNT_H, 16'h0010);
    wr16(A_RLD_H, 16'h0013);
    wr(A_STAT, 8'h03);
    base = irq_seen;
    wr(A_CTRL0, 8'h80);
    repeat (3) @(negedge clk);
    chk("R4 no irq before match", 16'(irq), 16'h0);
    chk("R5 level before match", 16'(tout), 16'h0);
    @(negedge clk);
    chk("R4 irq on match", 16'(irq), 16'h1);
    chk("R5 toggle on match", 16'(tout), 16'h1);
    @(negedge clk);
    chk("R4 irq one cycle", 16'(irq), 16'h0);
    repeat (5) @(negedge clk);
    wr(A_CTRL0, 8'h00);
    rd16(A_CNT_H, v); chk("R4 counting continues", v, 16'h001B);
    chk("R7 idle level low", 16'(tout), 16'h0);
    chk("R4 single irq", 16'(irq_seen - base), 16'h1);
    rd8(A_STAT, b); chk("R4 status bit1", 16'(b), 16'h0002);
    wr(A_STAT, 8'h02);
    rd8(A_STAT, b); chk("R12 write-one clear", 16'(b), 16'h0000);
    wr(A_CTRL0, 8'h20);
    @(negedge clk);
    chk("R7 idle level high", 16'(tout), 16'h1);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    int base;
    wr(A_CTRL1, 8'h00);
    wr16(A_CNT_H, 16'hFFFE);
    wr16(A_RLD_H, 16'h0001);
    base = irq_seen;
    wr(A_CTRL0, 8'hA0);
    repeat (4) @(negedge clk);
    chk("R4 irq after wrap", 16'(irq), 16'h1);
    chk("R5 output disabled holds", 16'(tout), 16'h1);
    repeat (2) @(negedge clk);
    wr(A_CTRL0, 8'h20);
    rd16(A_CNT_H, v); chk("R6 wrap to zero", v, 16'h0005);
    chk("R6 irq count", 16'(irq_seen - base), 16'h1);
  endtask

  task automatic t_coherent;
    logic [15:0] v;
    wr16(A_CNT_H, 16'h00FE);
    wr16(A_RLD_H, 16'hFFFF);
    wr(A_CTRL0, 8'h80);
    @(negedge clk);
    rd16(A_CNT_H, v); chk("R11 coherent read", v, 16'h00FF);
    wr(A_CTRL0, 8'h00);
  endtask

  task automatic t_reload;
    logic [15:0] v;
    logic [7:0]  b;
    int base;
    wr16(A_CNT_H, 16'h0003);
    wr16(A_RLD_H, 16'h0005);
    wr(A_STAT, 8'h03);
    base = irq_seen;
    wr(A_CTRL0, 8'hC2);
    repeat (3) @(negedge clk);
    chk("R8 reload irq", 16'(irq), 16'h1);
    @(negedge clk);
    rd16(A_CNT_H, v); chk("R8 restart at one", v, 16'h0002);
    wr(A_CTRL0, 8'h42);
    chk("R10 reload only irq count", 16'(irq_seen - base), 16'h1);
    rd8(A_STAT, b); chk("R8 reload flag only", 16'(b), 16'h0002);
    rd16(A_CAP_H, v); chk("R8 capture untouched", v, 16'h0000);
  endtask

  task automatic t_capture;
    logic [15:0] v;
    logic [7:0]  b;
    int base;
    wr(A_STAT, 8'h03);
    wr16(A_CNT_H, 16'h1234);
    wr16(A_RLD_H, 16'hFFFF);
    wr(A_CTRL1, 8'h01);
    base = irq_seen;
    wr(A_CTRL0, 8'hDD);
    tin = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 capture irq", 16'(irq_seen - base), 16'h1);
    rd16(A_CAP_H, v); chk("R9 captured count", v, 16'h1234);
    rd8(A_STAT, b); chk("R9 capture flag", 16'(b), 16'h0001);
    wr16(A_CAP_H, 16'h0000);
    tin = 1'b0;
    repeat (6) @(negedge clk);
    rd16(A_CAP_H, v); chk("R9 wrong edge ignored", v, 16'h0000);
    chk("R9 no irq on wrong edge", 16'(irq_seen - base), 16'h1);
    wr(A_CTRL0, 8'hDE);
    tin = 1'b1;
    repeat (6) @(negedge clk);
    rd16(A_CAP_H, v); chk("R10 masked capture still copies", v, 16'h1234);
    chk("R10 capture masked", 16'(irq_seen - base), 16'h1);
    wr(A_CTRL0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_compare();
    t_wrap();
    t_coherent();
    t_reload();
    t_capture();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscmp++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end
endmodule